// File: doc/BRIEF.md
# Dual-Issue Pairing and Hazard Stall Controller

This block sits between the decoder and the execution units of an in-order processor that can start up to two instructions per clock. Every cycle it is shown an older and a younger decoded candidate. Each candidate lists two source register numbers, each with a use bit. It also lists a destination register with a write-enable, a 2-bit execution-resource class, a flag-write bit, a flag-read bit and a load bit. From these the controller decides whether both candidates start, only the older one, or neither.

Two kinds of latency are tracked. A load's destination register becomes readable only after two further cycles. The condition flags written by an instruction cannot be read in the very next cycle. Load destinations are held in a scoreboard with one down-counter per register. A single counter covers outstanding flag updates. A flush input clears every pending counter.

The front end is expected to present the same pair again when nothing issues. When only the older candidate issues, the front end moves the younger candidate into the older slot.

Top module: `dual_issue_ctl`

## Requirements
- R1: When both candidates are valid and have different resource classes, and neither has a hazard, and the younger does not depend on the older, issue_valid is 2'b11 and stall is 0.
- R2: Two valid candidates with equal 2-bit class codes never issue together. Only the older issues (issue_valid = 2'b01).
- R3: The younger candidate is held (issue_valid = 2'b01) if a source it uses, with its use bit set, equals the older candidate's destination while the older one's write-enable is set. It is also held if it reads the flags and the older candidate writes them.
- R4: In the cycle right after an issued instruction writes the flags, a flag reader in the older slot does not issue and stall is 1. The cycle after that, it issues.
- R5: For the two cycles after a load issues, an older-slot candidate that reads the load's destination through either source field does not issue and stall is 1. On the third cycle it issues. A source field whose use bit is clear never causes a stall.
- R6: issue_valid is never 2'b10. Whenever the older candidate is stalled, issue_valid is 2'b00 and stall is 1, even if the younger has no hazard.
- R7: A younger candidate that has its own pending load or flag hazard is held while the older one issues (issue_valid = 2'b01, stall = 0).
- R8: While flush is 1, issue_valid is 2'b00 and stall is 0. All pending load and flag counters are cleared, so the next cycle shows no hazard.
- R9: While rst is 1, issue_valid is 2'b00 and stall is 0. After reset is released, no hazard remains from before the reset.
- R10: If the older candidate is not valid, nothing issues and stall is 0.
- R11: A load or flag write that issues from the younger slot creates the same hazards as one that issues from the older slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears all pending latency counters and blocks issue this cycle |
| cand_valid | input | 2 | Candidate valid; bit 0 is the older slot |
| cand_rs_a | input | 2 x REG_W | First source register per slot |
| cand_use_a | input | 2 | First source is read |
| cand_rs_b | input | 2 x REG_W | Second source register per slot |
| cand_use_b | input | 2 | Second source is read |
| cand_rd | input | 2 x REG_W | Destination register per slot |
| cand_rd_we | input | 2 | Destination is written |
| cand_cls | input | 2 x 2 | Execution-resource class code per slot |
| cand_wflag | input | 2 | Candidate writes the flags |
| cand_rflag | input | 2 | Candidate reads the flags |
| cand_load | input | 2 | Candidate is a load |
| issue_valid | output | 2 | Issue grant per slot |
| stall | output | 1 | Older candidate held by a latency hazard |

## Verification
A counter that is loaded with the wrong value, or that decrements wrongly, shows up at the ports one or two cycles after the producer issues. A dependent candidate in the older slot either issues one cycle too soon or keeps stall high one cycle too long. Slot mix-ups show up in the same cycle as a wrong issue_valid pattern, for example a pair that was allowed to issue or a grant of 2'b10. A flush or reset that does not clear the counters shows up as a stall in the first cycle after it.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  // width of the execution-resource class code
  localparam int CLS_W = 2;

  // grant patterns; slot 0 is the older candidate
  typedef enum logic [1:0] {
    ISS_NONE = 2'b00,
    ISS_OLD  = 2'b01,
    ISS_BOTH = 2'b11
  } issue_e;

endpackage

// File: rtl/load_scoreboard.sv
module load_scoreboard #(
  parameter int NUM_REGS = 16,
  parameter int LOAD_LAT = 2,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int CNT_W = $clog2(LOAD_LAT + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic [1:0]             set_en,
  input  logic [1:0][REG_W-1:0]  set_reg,
  output logic [NUM_REGS-1:0]    busy
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit = (set_en[0] && set_reg[0] == REG_W'(r)) ||
                 (set_en[1] && set_reg[1] == REG_W'(r));

    always_ff @(posedge clk) begin
      if (rst || flush) begin
        cnt_q <= '0;
      end else if (hit) begin
        cnt_q <= CNT_W'(LOAD_LAT);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end

    assign busy[r] = (cnt_q != '0);

    // R5: a counter never holds more than the load latency
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(LOAD_LAT));
  end

  // R5: a load issued from the older slot makes its destination busy
  p_busy_after_load_r5: assert property (@(posedge clk) disable iff (rst)
    (set_en[0] && !flush) |=> busy[$past(set_reg[0])]);

  // R11: a load issued from the younger slot does the same
  p_busy_after_young_load_r11: assert property (@(posedge clk) disable iff (rst)
    (set_en[1] && !flush) |=> busy[$past(set_reg[1])]);

  // R8: flush leaves no pending load
  p_flush_clear_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (busy == '0));

endmodule

// File: rtl/flag_tracker.sv
module flag_tracker #(
  parameter int FLAG_LAT = 1,
  localparam int CNT_W = $clog2(FLAG_LAT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic set_en,
  output logic busy
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q <= '0;
    end else if (set_en) begin
      cnt_q <= CNT_W'(FLAG_LAT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy = (cnt_q != '0);

  // R4: the flags are busy in the cycle after a flag write issues
  p_flag_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (set_en && !flush) |=> busy);

  // R8: flush leaves no pending flag update
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !busy);

endmodule

// File: rtl/pair_select.sv
module pair_select import dual_issue_pkg::*; #(
  parameter int NUM_REGS = 16,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                  block,
  input  logic [1:0]            cand_valid,
  input  logic [1:0][REG_W-1:0] cand_rs_a,
  input  logic [1:0]            cand_use_a,
  input  logic [1:0][REG_W-1:0] cand_rs_b,
  input  logic [1:0]            cand_use_b,
  input  logic [1:0][REG_W-1:0] cand_rd,
  input  logic [1:0]            cand_rd_we,
  input  logic [1:0][CLS_W-1:0] cand_cls,
  input  logic [1:0]            cand_wflag,
  input  logic [1:0]            cand_rflag,
  input  logic [NUM_REGS-1:0]   reg_busy,
  input  logic                  flag_busy,
  output issue_e                grant,
  output logic                  stall
);

  logic [1:0] hazard;
  logic       young_dep;
  logic       cls_clash;
  logic       go_old;
  logic       go_young;

  // hazard from pending latency, one per slot
  for (genvar s = 0; s < 2; s++) begin : g_haz
    assign hazard[s] = (cand_use_a[s] && reg_busy[cand_rs_a[s]]) ||
                       (cand_use_b[s] && reg_busy[cand_rs_b[s]]) ||
                       (cand_rflag[s] && flag_busy);
  end

  // the younger consumes something the older produces
  assign young_dep = (cand_rd_we[0] &&
                       ((cand_use_a[1] && cand_rs_a[1] == cand_rd[0]) ||
                        (cand_use_b[1] && cand_rs_b[1] == cand_rd[0]))) ||
                     (cand_wflag[0] && cand_rflag[1]);

  assign cls_clash = (cand_cls[0] == cand_cls[1]);

  assign go_old   = !block && cand_valid[0] && !hazard[0];
  assign go_young = go_old && cand_valid[1] && !hazard[1] &&
                    !young_dep && !cls_clash;

  always_comb begin
    if (go_young)    grant = ISS_BOTH;
    else if (go_old) grant = ISS_OLD;
    else             grant = ISS_NONE;
  end

  assign stall = !block && cand_valid[0] && hazard[0];

endmodule

// File: rtl/dual_issue_ctl.sv
module dual_issue_ctl import dual_issue_pkg::*; #(
  parameter int NUM_REGS = 16,
  parameter int LOAD_LAT = 2,
  parameter int FLAG_LAT = 1,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic [1:0]            cand_valid,
  input  logic [1:0][REG_W-1:0] cand_rs_a,
  input  logic [1:0]            cand_use_a,
  input  logic [1:0][REG_W-1:0] cand_rs_b,
  input  logic [1:0]            cand_use_b,
  input  logic [1:0][REG_W-1:0] cand_rd,
  input  logic [1:0]            cand_rd_we,
  input  logic [1:0][CLS_W-1:0] cand_cls,
  input  logic [1:0]            cand_wflag,
  input  logic [1:0]            cand_rflag,
  input  logic [1:0]            cand_load,
  output logic [1:0]            issue_valid,
  output logic                  stall
);

  logic [NUM_REGS-1:0] reg_busy;
  logic                flag_busy;
  logic [1:0]          ld_set;
  logic                flag_set;
  issue_e              grant;

  for (genvar s = 0; s < 2; s++) begin : g_set
    assign ld_set[s] = issue_valid[s] && cand_load[s] && cand_rd_we[s];
  end

  assign flag_set = (issue_valid[0] && cand_wflag[0]) ||
                    (issue_valid[1] && cand_wflag[1]);

  load_scoreboard #(
    .NUM_REGS (NUM_REGS),
    .LOAD_LAT (LOAD_LAT)
  ) u_sb (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .set_en  (ld_set),
    .set_reg (cand_rd),
    .busy    (reg_busy)
  );

  flag_tracker #(
    .FLAG_LAT (FLAG_LAT)
  ) u_flag (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .set_en (flag_set),
    .busy   (flag_busy)
  );

  pair_select #(
    .NUM_REGS (NUM_REGS)
  ) u_pair (
    .block      (rst || flush),
    .cand_valid (cand_valid),
    .cand_rs_a  (cand_rs_a),
    .cand_use_a (cand_use_a),
    .cand_rs_b  (cand_rs_b),
    .cand_use_b (cand_use_b),
    .cand_rd    (cand_rd),
    .cand_rd_we (cand_rd_we),
    .cand_cls   (cand_cls),
    .cand_wflag (cand_wflag),
    .cand_rflag (cand_rflag),
    .reg_busy   (reg_busy),
    .flag_busy  (flag_busy),
    .grant      (grant),
    .stall      (stall)
  );

  assign issue_valid = grant;

  // R6: the younger never issues alone
  p_in_order_r6: assert property (@(posedge clk) disable iff (rst)
    issue_valid != 2'b10);

  // R6: a stall grants nothing
  p_stall_idle_r6: assert property (@(posedge clk) disable iff (rst)
    stall |-> issue_valid == 2'b00);

  // R2: a granted pair uses two different resources
  p_class_split_r2: assert property (@(posedge clk) disable iff (rst)
    issue_valid[1] |-> cand_cls[0] != cand_cls[1]);

  // R3: a granted pair never passes flags from older to younger
  p_no_flag_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid[1] && cand_wflag[0]) |-> !cand_rflag[1]);

  // R8: nothing issues during flush
  p_flush_idle_r8: assert property (@(posedge clk) disable iff (rst)
    flush |-> (issue_valid == 2'b00 && !stall));

  // R10: an empty older slot grants nothing
  p_empty_old_r10: assert property (@(posedge clk) disable iff (rst)
    !cand_valid[0] |-> (issue_valid == 2'b00 && !stall));

endmodule

// File: tb/sim_dual_issue_ctl.sv
module sim_dual_issue_ctl;

  localparam int RW = 4;
  localparam int NV = 25;

  typedef struct packed {
    logic          v;
    logic [RW-1:0] rsa;
    logic          ua;
    logic [RW-1:0] rsb;
    logic          ub;
    logic [RW-1:0] rd;
    logic          we;
    logic [1:0]    cls;
    logic          wf;
    logic          rf;
    logic          ld;
  } slot_t;

  typedef struct packed {
    slot_t      o;
    slot_t      y;
    logic       fl;
    logic [1:0] iss;
    logic       st;
    logic [3:0] req;
  } vec_t;

  // class codes: 0 arithmetic, 1 compare, 2 memory, 3 misc
  function automatic slot_t nop();
    slot_t s = '0;
    return s;
  endfunction

  function automatic slot_t alu(int d, int a, int b);
    slot_t s = '0;
    s.v = 1; s.rsa = RW'(a); s.ua = 1; s.rsb = RW'(b); s.ub = 1;
    s.rd = RW'(d); s.we = 1; s.cls = 2'd0;
    return s;
  endfunction

  function automatic slot_t alu_nb(int d, int a, int b);
    slot_t s = alu(d, a, b);
    s.ub = 0;
    return s;
  endfunction

  function automatic slot_t cmp(int a, int b);
    slot_t s = '0;
    s.v = 1; s.rsa = RW'(a); s.ua = 1; s.rsb = RW'(b); s.ub = 1;
    s.cls = 2'd1; s.wf = 1;
    return s;
  endfunction

  function automatic slot_t ld(int d, int a);
    slot_t s = '0;
    s.v = 1; s.rsa = RW'(a); s.ua = 1; s.rd = RW'(d); s.we = 1;
    s.cls = 2'd2; s.ld = 1;
    return s;
  endfunction

  function automatic slot_t rdf(int d);
    slot_t s = '0;
    s.v = 1; s.rd = RW'(d); s.we = 1; s.cls = 2'd3; s.rf = 1;
    return s;
  endfunction

  function automatic vec_t mk(slot_t o, slot_t y, logic fl, logic [1:0] iss,
                              logic st, int req);
    vec_t x;
    x.o = o; x.y = y; x.fl = fl; x.iss = iss; x.st = st; x.req = 4'(req);
    return x;
  endfunction

  localparam vec_t VT [NV] = '{
    mk(alu(1,2,3),    cmp(4,5),      0, 2'b11, 0, 1),  // R1
    mk(alu(1,2,3),    alu(6,7,8),    0, 2'b01, 0, 2),  // R2
    mk(alu(2,3,4),    cmp(2,5),      0, 2'b01, 0, 3),  // R3 register
    mk(cmp(1,2),      rdf(6),        0, 2'b01, 0, 3),  // R3 flags
    mk(rdf(6),        nop(),         0, 2'b00, 1, 4),  // R4
    mk(rdf(6),        nop(),         0, 2'b01, 0, 4),  // R4
    mk(ld(9,10),      alu(11,12,13), 0, 2'b11, 0, 1),  // R1
    mk(alu(3,9,1),    nop(),         0, 2'b00, 1, 5),  // R5
    mk(alu(3,9,1),    nop(),         0, 2'b00, 1, 5),  // R5
    mk(alu(3,9,1),    nop(),         0, 2'b01, 0, 5),  // R5
    mk(ld(5,6),       alu(7,1,2),    0, 2'b11, 0, 1),  // R1
    mk(alu_nb(8,1,5), cmp(3,4),      0, 2'b11, 0, 5),  // R5 use bit
    mk(cmp(1,2),      alu(4,5,1),    0, 2'b01, 0, 7),  // R7
    mk(alu(4,1,2),    rdf(9),        0, 2'b01, 0, 7),  // R7
    mk(alu(1,2,3),    ld(12,13),     0, 2'b11, 0, 11), // R11
    mk(alu(14,12,0),  nop(),         0, 2'b00, 1, 11), // R11
    mk(alu(14,12,0),  nop(),         1, 2'b00, 0, 8),  // R8
    mk(alu(14,12,0),  nop(),         0, 2'b01, 0, 8),  // R8
    mk(nop(),         alu(1,2,3),    0, 2'b00, 0, 10), // R10
    mk(ld(2,3),       ld(4,5),       0, 2'b01, 0, 2),  // R2
    mk(alu(6,4,4),    cmp(7,8),      0, 2'b11, 0, 2),  // R2
    mk(cmp(2,1),      nop(),         0, 2'b00, 1, 5),  // R5
    mk(alu(1,2,3),    cmp(4,5),      0, 2'b11, 0, 11), // R11
    mk(rdf(6),        nop(),         0, 2'b00, 1, 11), // R11
    mk(rdf(6),        nop(),         0, 2'b01, 0, 11)  // R11
  };

  logic            clk = 0;
  logic            rst = 1;
  logic            flush = 0;
  logic [1:0]      cand_valid;
  logic [1:0][RW-1:0] cand_rs_a, cand_rs_b, cand_rd;
  logic [1:0]      cand_use_a, cand_use_b, cand_rd_we;
  logic [1:0][1:0] cand_cls;
  logic [1:0]      cand_wflag, cand_rflag, cand_load;
  logic [1:0]      issue_valid;
  logic            stall;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_issue_ctl u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .cand_valid(cand_valid), .cand_rs_a(cand_rs_a), .cand_use_a(cand_use_a),
    .cand_rs_b(cand_rs_b), .cand_use_b(cand_use_b), .cand_rd(cand_rd),
    .cand_rd_we(cand_rd_we), .cand_cls(cand_cls), .cand_wflag(cand_wflag),
    .cand_rflag(cand_rflag), .cand_load(cand_load),
    .issue_valid(issue_valid), .stall(stall)
  );

  task automatic drive(slot_t o, slot_t y, logic fl);
    slot_t s [2];
    s[0] = o; s[1] = y;
    for (int i = 0; i < 2; i++) begin
      cand_valid[i] = s[i].v;  cand_rs_a[i] = s[i].rsa; cand_use_a[i] = s[i].ua;
      cand_rs_b[i]  = s[i].rsb; cand_use_b[i] = s[i].ub; cand_rd[i] = s[i].rd;
      cand_rd_we[i] = s[i].we; cand_cls[i] = s[i].cls;  cand_wflag[i] = s[i].wf;
      cand_rflag[i] = s[i].rf; cand_load[i] = s[i].ld;
    end
    flush = fl;
  endtask

  task automatic check(int req, logic [1:0] e_iss, logic e_st);
    n_chk++;
    if (issue_valid !== e_iss || stall !== e_st) begin
      n_bad++;
      $display("FAIL R%0d: issue_valid=%b stall=%b, expected issue_valid=%b stall=%b",
               req, issue_valid, stall, e_iss, e_st);
    end
  endtask

  // drive on the falling edge, sample just before the rising edge
  task automatic step(slot_t o, slot_t y, logic fl, int req,
                      logic [1:0] e_iss, logic e_st);
    @(negedge clk);
    drive(o, y, fl);
    #4;
    check(req, e_iss, e_st);
  endtask

  initial begin
    drive(nop(), nop(), 0);
    // R9: nothing issues while reset is held, even with a ready candidate
    step(alu(1,2,3), cmp(4,5), 0, 9, 2'b00, 0);
    step(alu(1,2,3), cmp(4,5), 0, 9, 2'b00, 0);
    @(negedge clk);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      step(VT[i].o, VT[i].y, VT[i].fl, int'(VT[i].req), VT[i].iss, VT[i].st);
    end

    // R6: older stalled, independent younger still waits
    step(ld(6,7), nop(), 0, 6, 2'b01, 0);
    step(alu(8,6,1), cmp(1,2), 0, 6, 2'b00, 1);

    // R9: reset drops a pending load
    step(ld(3,4), nop(), 0, 9, 2'b01, 0);
    @(negedge clk);
    rst = 1;
    drive(alu(5,3,3), nop(), 0);
    #4;
    check(9, 2'b00, 0);
    @(negedge clk);
    rst = 0;
    drive(alu(5,3,3), nop(), 0);
    #4;
    check(9, 2'b01, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule